// File: doc/BRIEF.md
# Wake-up Interval and Check-Point Timer

This block paces a receiver that sleeps most of the time and wakes at a programmed interval. One timer counts a coarse 10 ms tick and pulses at the start of every wake cycle. A second timer counts a fine 1 ms tick. It is armed by an oscillator-start pulse, and it pulses twice. The first pulse is the first check point, where the signal level is tested. The second pulse is the second check point, where the header is tested. Ticks come from outside the block as one-clock strobes. Only ticks are counted, never clocks.

The wake interval is set by a 9-bit code. The top two bits pick a prescale of 1, 16 or 256, and the low seven bits give the count N. The first delay is set by a 7-bit code. Its top bit picks a prescale of 1 or 16, and the low six bits give N. The second delay is a 3-bit multiple K of the first delay.

Codes are held in shadow registers. While the sequence is disabled, the shadows follow the input pins. While it is enabled, they are refreshed only at a wake-cycle start. Reset is asynchronous and active low, and its release is synchronised in two stages.

Top module: `wk_wake_timer`

## Requirements
- R1: After reset all three pulse outputs are low. The shadow codes reset to wake code 0x5F (96 ticks), delay-1 code 0x04 (5 ticks) and delay-2 multiple 2. These defaults govern behaviour when the enable is held high through reset.
- R2: With wake code bits [8:7] = 00, `cycle_start` pulses every N+1 ticks of `tick_10ms`, where N = code[6:0].
- R3: With code bits [8:7] = 01 or 10, the wake interval is 16·N+1 ticks. With 11, it is 256·N+1 ticks. For example, code 0x181 gives 257 ticks.
- R4: `test1` pulses after (N+1)·Q ticks of `tick_1ms` following `osc_start`, where N = delay-1 code[5:0]. Q is 16 when code bit 6 is 1 and 1 otherwise.
- R5: `test2` pulses after K further delay-1 intervals, where K is the 3-bit delay-2 multiple. With K = 0, `test2` pulses in the same cycle as `test1`. Each `osc_start` yields exactly one `test1` and one `test2`.
- R6: `osc_start` restarts the delay count even while a count is in progress. A `tick_1ms` in the same cycle as `osc_start` is not counted.
- R7: While `seq_en` is low, all counters are cleared and no pulse is issued, whatever the ticks or `osc_start` do. After `seq_en` rises again, counting starts from zero.
- R8: While enabled, a changed wake code first applies to the interval that begins at the next `cycle_start`. Delay codes are taken from the shadows, which are refreshed only at `cycle_start` or while disabled, so a pin change while enabled does not alter the next delay sequence.
- R9: Every output pulse lasts one clock. It appears in the cycle after the clock edge that accepts the tick completing the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_en | input | 1 | Sequence enable; low clears all counters |
| tick_10ms | input | 1 | Coarse tick strobe for the wake interval |
| tick_1ms | input | 1 | Fine tick strobe for the check-point delays |
| osc_start | input | 1 | Reference oscillator started; arms the delays |
| per_code | input | 9 | Wake interval code: [8:7] prescale, [6:0] N |
| d1_code | input | 7 | Delay-1 code: [6] prescale, [5:0] N |
| d2_code | input | 3 | Delay-2 multiple of delay 1 |
| cycle_start | output | 1 | One-clock pulse at each wake-cycle start |
| test1 | output | 1 | One-clock pulse at the first check point |
| test2 | output | 1 | One-clock pulse at the second check point |

## Verification
The reset defaults are the hardest case to reach from the ports. Any cycle with the enable low copies the pins into the shadows, so the defaults are overwritten at once. The bench therefore holds `seq_en` high through reset with pin codes far from the defaults, and times both delays and one full wake interval against the default lengths. The one-cycle lag of the shadows is exercised by changing the wake code right after a cycle start and checking that the following interval still uses the old length. The rest of the bench sweeps every delay-1 code, every ×1 wake code and a band of ×16 and ×256 codes, and computes each expected length arithmetically.

// File: rtl/wk_timer_pkg.sv
package wk_timer_pkg;
  localparam int PER_CODE_W = 9;
  localparam int D1_CODE_W  = 7;
  localparam int D2_CODE_W  = 3;
  localparam int PER_LEN_W  = 15;
  localparam int D1_LEN_W   = 11;

  // wake interval length in coarse ticks
  function automatic logic [PER_LEN_W-1:0] period_len(input logic [PER_CODE_W-1:0] code);
    logic [PER_LEN_W-1:0] n;
    n = PER_LEN_W'(code[6:0]);
    case (code[8:7])
      2'b00:   return n + 1'b1;
      2'b11:   return (n << 8) + 1'b1;
      default: return (n << 4) + 1'b1;
    endcase
  endfunction

  // first delay length in fine ticks
  function automatic logic [D1_LEN_W-1:0] delay1_len(input logic [D1_CODE_W-1:0] code);
    logic [D1_LEN_W-1:0] n;
    n = D1_LEN_W'(code[5:0]) + 1'b1;
    return code[6] ? (n << 4) : n;
  endfunction
endpackage

// File: rtl/wk_period_timer.sv
module wk_period_timer
  import wk_timer_pkg::*;
#(
  parameter logic [PER_CODE_W-1:0] PER_RST = 9'h05F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  tick,
  input  logic [PER_CODE_W-1:0] code,
  output logic                  start_o
);
  logic [PER_CODE_W-1:0] code_q, code_d;
  logic [PER_LEN_W-1:0]  cnt_q, cnt_d, len;
  logic                  start_q, wrap;

  always_comb begin
    len   = period_len(code_q);
    wrap  = en && tick && (cnt_q == len - 1'b1);
    cnt_d = cnt_q;
    if (!en || wrap) cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + 1'b1;
    code_d = (!en || wrap) ? code : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= PER_RST;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      code_q  <= code_d;
      cnt_q   <= cnt_d;
      start_q <= wrap;
    end
  end

  assign start_o = start_q;

  a_r2_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len);
  a_r9_start_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(tick && en));
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !start_q);
  a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !start_q) |-> $stable(code_q));
endmodule

// File: rtl/wk_delay_timer.sv
module wk_delay_timer
  import wk_timer_pkg::*;
#(
  parameter logic [D1_CODE_W-1:0] D1_RST = 7'h04,
  parameter logic [D2_CODE_W-1:0] D2_RST = 3'd2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 tick,
  input  logic                 osc_start,
  input  logic [D1_CODE_W-1:0] d1_code,
  input  logic [D2_CODE_W-1:0] d2_code,
  output logic                 t1_o,
  output logic                 t2_o
);
  logic                 act_q, act_d, ph2_q, ph2_d;
  logic [D1_LEN_W-1:0]  cnt_q, cnt_d, len_q, len_d;
  logic [D2_CODE_W-1:0] rep_q, rep_d, mul_q, mul_d;
  logic                 t1_q, t1_d, t2_q, t2_d, seg_end;

  always_comb begin
    act_d = act_q; ph2_d = ph2_q; cnt_d = cnt_q; rep_d = rep_q;
    len_d = len_q; mul_d = mul_q; t1_d = 1'b0; t2_d = 1'b0;
    seg_end = act_q && tick && (cnt_q == len_q - 1'b1);
    if (!en) begin
      act_d = 1'b0; ph2_d = 1'b0; cnt_d = '0; rep_d = '0;
    end else if (osc_start) begin
      act_d = 1'b1; ph2_d = 1'b0; cnt_d = '0; rep_d = '0;
      len_d = delay1_len(d1_code);
      mul_d = d2_code;
    end else if (act_q && tick) begin
      if (seg_end) begin
        cnt_d = '0;
        if (!ph2_q) begin
          t1_d = 1'b1;
          if (mul_q == '0) begin
            t2_d  = 1'b1;
            act_d = 1'b0;
          end else begin
            ph2_d = 1'b1;
            rep_d = '0;
          end
        end else if (rep_q == mul_q - 1'b1) begin
          t2_d  = 1'b1;
          act_d = 1'b0;
          ph2_d = 1'b0;
        end else begin
          rep_d = rep_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; ph2_q <= 1'b0; cnt_q <= '0; rep_q <= '0;
      len_q <= delay1_len(D1_RST); mul_q <= D2_RST;
      t1_q  <= 1'b0; t2_q <= 1'b0;
    end else begin
      act_q <= act_d; ph2_q <= ph2_d; cnt_q <= cnt_d; rep_q <= rep_d;
      len_q <= len_d; mul_q <= mul_d;
      t1_q  <= t1_d;  t2_q  <= t2_d;
    end
  end

  assign t1_o = t1_q;
  assign t2_o = t2_q;

  a_r4_seg_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < len_q));
  a_r5_rep_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ph2_q |-> (rep_q < mul_q));
  a_r5_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_q && mul_q == '0) |-> t2_q);
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(t1_q || t2_q));
endmodule

// File: rtl/wk_wake_timer.sv
module wk_wake_timer
  import wk_timer_pkg::*;
#(
  parameter int                    SYNC_STAGES = 2,
  parameter logic [PER_CODE_W-1:0] PER_RST     = 9'h05F,
  parameter logic [D1_CODE_W-1:0]  D1_RST      = 7'h04,
  parameter logic [D2_CODE_W-1:0]  D2_RST      = 3'd2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  seq_en,
  input  logic                  tick_10ms,
  input  logic                  tick_1ms,
  input  logic                  osc_start,
  input  logic [PER_CODE_W-1:0] per_code,
  input  logic [D1_CODE_W-1:0]  d1_code,
  input  logic [D2_CODE_W-1:0]  d2_code,
  output logic                  cycle_start,
  output logic                  test1,
  output logic                  test2
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sn;
  logic [D1_CODE_W-1:0]   d1_sh_q, d1_sh_d;
  logic [D2_CODE_W-1:0]   d2_sh_q, d2_sh_d;

  // reset asserted at once, released through a synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sn = sync_q[SYNC_STAGES-1];

  always_comb begin
    d1_sh_d = d1_sh_q;
    d2_sh_d = d2_sh_q;
    if (!seq_en || cycle_start) begin
      d1_sh_d = d1_code;
      d2_sh_d = d2_code;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      d1_sh_q <= D1_RST;
      d2_sh_q <= D2_RST;
    end else begin
      d1_sh_q <= d1_sh_d;
      d2_sh_q <= d2_sh_d;
    end
  end

  wk_period_timer #(.PER_RST(PER_RST)) i_period (
    .clk     (clk),
    .rst_n   (rst_sn),
    .en      (seq_en),
    .tick    (tick_10ms),
    .code    (per_code),
    .start_o (cycle_start)
  );

  wk_delay_timer #(.D1_RST(D1_RST), .D2_RST(D2_RST)) i_delay (
    .clk       (clk),
    .rst_n     (rst_sn),
    .en        (seq_en),
    .tick      (tick_1ms),
    .osc_start (osc_start),
    .d1_code   (d1_sh_q),
    .d2_code   (d2_sh_q),
    .t1_o      (test1),
    .t2_o      (test2)
  );

  a_r8_shadow_held: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(seq_en) && !$past(cycle_start)) |-> ($stable(d1_sh_q) && $stable(d2_sh_q)));
endmodule

// File: tb/test_wk_wake_timer.sv
module test_wk_wake_timer;
  logic       clk = 1'b0;
  logic       rst_n, seq_en, tick_10ms, tick_1ms, osc_start;
  logic [8:0] per_code;
  logic [6:0] d1_code;
  logic [2:0] d2_code;
  logic       cycle_start, test1, test2;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  wk_wake_timer i_wk_wake_timer (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .tick_10ms(tick_10ms),
    .tick_1ms(tick_1ms), .osc_start(osc_start), .per_code(per_code),
    .d1_code(d1_code), .d2_code(d2_code), .cycle_start(cycle_start),
    .test1(test1), .test2(test2)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int per_len(input logic [8:0] c);
    int n = int'(c[6:0]);
    if (c[8:7] == 2'b00) return n + 1;
    if (c[8:7] == 2'b11) return 256 * n + 1;
    return 16 * n + 1;
  endfunction

  function automatic int d1_len(input logic [6:0] c);
    return (int'(c[5:0]) + 1) * (c[6] ? 16 : 1);
  endfunction

  // two wake intervals, ticks every (gap+1) clocks
  task automatic measure_period(input logic [8:0] code, input int gap, input string req);
    int ticks = 0;
    int seen  = 0;
    int exp   = per_len(code);
    int limit = exp * 2 * (gap + 1) + 20;
    seq_en = 1'b0; per_code = code;
    @(negedge clk); @(negedge clk);
    seq_en = 1'b1;
    for (int c = 0; c < limit && seen < 2; c++) begin
      @(negedge clk);
      if (cycle_start) begin
        seen++;
        chk(ticks == exp * seen, req, ticks, exp * seen);
      end
      tick_10ms = (c % (gap + 1) == 0);
      if (tick_10ms) ticks++;
    end
    tick_10ms = 1'b0;
    if (seen < 2) chk(1'b0, req, seen, 2);
    seq_en = 1'b0;
  endtask

  // delay sequence; d1l is put on the pin after enabling
  task automatic measure_delay(input logic [6:0] d1, input logic [2:0] d2,
                               input logic [6:0] d1l, input int e1, input int e2,
                               input string req);
    int ticks = 0;
    int at1 = -1;
    int at2 = -1;
    int n1 = 0;
    int n2 = 0;
    seq_en = 1'b0; d1_code = d1; d2_code = d2;
    @(negedge clk);
    seq_en = 1'b1; d1_code = d1l;
    @(negedge clk);
    osc_start = 1'b1;
    @(negedge clk);
    osc_start = 1'b0;
    for (int c = 0; c < e2 + 12; c++) begin
      if (test1) begin n1++; if (at1 < 0) at1 = ticks; end
      if (test2) begin n2++; if (at2 < 0) at2 = ticks; end
      tick_1ms = 1'b1; ticks++;
      @(negedge clk);
    end
    tick_1ms = 1'b0;
    chk(at1 == e1, {req, " test1 time"}, at1, e1);
    chk(at2 == e2, {req, " test2 time"}, at2, e2);
    chk(n1 == 1 && n2 == 1, {req, " one pulse each"}, n1 + n2, 2);
    seq_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ticks, at1, at2, n;
    rst_n = 1'b0; tick_10ms = 1'b0; tick_1ms = 1'b0; osc_start = 1'b0;
    // R1: enable held through reset, pins far from defaults
    seq_en = 1'b1; per_code = 9'h000; d1_code = 7'h7F; d2_code = 3'd7;
    repeat (3) @(negedge clk);
    chk(!cycle_start && !test1 && !test2, "R1 reset outputs", int'(cycle_start), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cycle_start && !test1 && !test2, "R1 after release", int'(test1), 0);
    osc_start = 1'b1; @(negedge clk); osc_start = 1'b0;
    ticks = 0; at1 = -1; at2 = -1;
    for (int c = 0; c < 40; c++) begin
      if (test1 && at1 < 0) at1 = ticks;
      if (test2 && at2 < 0) at2 = ticks;
      tick_1ms = 1'b1; ticks++;
      @(negedge clk);
    end
    tick_1ms = 1'b0;
    chk(at1 == 5, "R1 default delay1", at1, 5);
    chk(at2 == 15, "R1 default delay2", at2, 15);
    ticks = 0; at1 = -1;
    for (int c = 0; c < 110; c++) begin
      if (cycle_start && at1 < 0) at1 = ticks;
      tick_10ms = 1'b1; ticks++;
      @(negedge clk);
    end
    tick_10ms = 1'b0;
    chk(at1 == 96, "R1 default wake interval", at1, 96);
    seq_en = 1'b0; @(negedge clk);

    // R2 and R9: every x1 code, plus sparse ticks
    for (int k = 0; k < 128; k++) measure_period(9'(k), 0, "R2 x1 interval");
    measure_period(9'h005, 3, "R9 sparse ticks");
    measure_period(9'h07F, 1, "R2 max x1 sparse");
    // R3: both x16 selects and x256
    for (int k = 0; k < 16; k++) measure_period({2'b01, 7'(k)}, 0, "R3 x16 sel01");
    for (int k = 0; k < 16; k++) measure_period({2'b10, 7'(k)}, 0, "R3 x16 sel10");
    for (int k = 0; k < 3; k++)  measure_period({2'b11, 7'(k)}, 0, "R3 x256");
    measure_period(9'h181, 2, "R3 code 0x181");

    // R4: every delay-1 code, K=0 so both pulses coincide (R5)
    for (int k = 0; k < 128; k++)
      measure_delay(7'(k), 3'd0, 7'(k), d1_len(7'(k)), d1_len(7'(k)), "R4 delay1");
    // R5: every multiple on a few delay-1 lengths
    for (int m = 1; m < 8; m++) begin
      measure_delay(7'h00, 3'(m), 7'h00, 1, 1 * (m + 1), "R5 multiple");
      measure_delay(7'h03, 3'(m), 7'h03, 4, 4 * (m + 1), "R5 multiple");
      measure_delay(7'h41, 3'(m), 7'h41, 32, 32 * (m + 1), "R5 multiple");
    end
    // R8: pin change while enabled does not reach the delay
    measure_delay(7'h01, 3'd0, 7'h05, 2, 2, "R8 delay code held");

    // R6: restart in flight, tick during osc_start ignored
    seq_en = 1'b0; d1_code = 7'h09; d2_code = 3'd0; @(negedge clk);
    seq_en = 1'b1; @(negedge clk);
    osc_start = 1'b1; @(negedge clk); osc_start = 1'b0;
    n = 0;
    for (int c = 0; c < 6; c++) begin
      tick_1ms = 1'b1; @(negedge clk);
      if (test1) n++;
    end
    osc_start = 1'b1; tick_1ms = 1'b1; @(negedge clk); osc_start = 1'b0;
    ticks = 0; at1 = -1;
    for (int c = 0; c < 20; c++) begin
      if (test1) begin n++; if (at1 < 0) at1 = ticks; end
      tick_1ms = 1'b1; ticks++;
      @(negedge clk);
    end
    tick_1ms = 1'b0;
    chk(at1 == 10, "R6 restart timing", at1, 10);
    chk(n == 1, "R6 single test1", n, 1);

    // R7: disable mid-count, stimulus while off, clean restart
    seq_en = 1'b0; d1_code = 7'h02; d2_code = 3'd1; per_code = 9'h000; @(negedge clk);
    seq_en = 1'b1; @(negedge clk);
    osc_start = 1'b1; @(negedge clk); osc_start = 1'b0;
    tick_1ms = 1'b1; @(negedge clk); @(negedge clk);
    seq_en = 1'b0;
    n = 0;
    for (int c = 0; c < 20; c++) begin
      tick_1ms = 1'b1; tick_10ms = 1'b1; osc_start = (c % 5 == 0);
      @(negedge clk);
      if (c > 0 && (cycle_start || test1 || test2)) n++;
    end
    osc_start = 1'b0; tick_10ms = 1'b0;
    chk(n == 0, "R7 no pulses while off", n, 0);
    seq_en = 1'b1; n = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (test1 || test2) n++;
    end
    tick_1ms = 1'b0;
    chk(n == 0, "R7 delay cleared on disable", n, 0);
    seq_en = 1'b0; per_code = 9'h002; @(negedge clk);
    seq_en = 1'b1;
    tick_10ms = 1'b1; @(negedge clk); @(negedge clk);
    seq_en = 1'b0; tick_10ms = 1'b0; @(negedge clk);
    seq_en = 1'b1;
    ticks = 0; at1 = -1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (cycle_start && at1 < 0) at1 = ticks;
      tick_10ms = 1'b1; ticks++;
    end
    tick_10ms = 1'b0;
    chk(at1 == 3, "R7 period count cleared", at1, 3);

    // R8: new wake code applies one interval late
    seq_en = 1'b0; per_code = 9'h003; @(negedge clk); @(negedge clk);
    seq_en = 1'b1;
    ticks = 0; n = 0;
    for (int c = 0; c < 40 && n < 3; c++) begin
      @(negedge clk);
      if (cycle_start) begin
        n++;
        if (n == 1) begin
          chk(ticks == 4, "R8 first interval", ticks, 4);
          per_code = 9'h005;
        end
        if (n == 2) chk(ticks == 8, "R8 old code kept", ticks, 8);
        if (n == 3) chk(ticks == 14, "R8 new code applied", ticks, 14);
      end
      tick_10ms = 1'b1; ticks++;
    end
    tick_10ms = 1'b0;
    chk(n == 3, "R8 pulse count", n, 3);
    seq_en = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule